// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a word-addressed timer peripheral built around one up-counter. The counter is stepped by one of three source tick strobes, chosen by a 3-bit source code and divided by a 12-bit prescaler. Three compare registers each raise a status flag when the counter steps onto their value. A rollover flag is raised when the counter wraps past all-ones. Status flags stick until software clears them by writing ones. Each flag is masked by an enable register, and the masked result drives a single level interrupt while the timer is enabled.

The counter runs in one of two modes. In free-running mode it simply wraps. In restart mode it returns to zero on the step after it has reached compare channel 1. In restart mode, a write to compare channel 1 also clears the counter. A mode bit in the control word decides whether turning the timer on clears the count or resumes from the held value. A self-clearing software-reset bit returns most of the block to its power-on state. The two capture slots can be read but always hold zero, because the block has no capture source.

Top module: `cmp_timer`

## Requirements
- R1: After rst_n is released, control, prescaler, status and interrupt-enable read 0, the counter reads 0, all three compare registers read all-ones (CNT_W bits), and irq is low.
- R2: Word offsets are: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare channels 1 to 3, 7 and 8 capture slots (always read 0), and 9 counter (read-only). Any other offset reads 0, and a write to it changes no register.
- R3: Control bit layout: bit 0 enable, bit 1 enable-mode, bit 3 debug, bit 5 wait, bit 6 doze, bit 7 stop, bit 8 software reset (always reads 0), bit 9 free-run, bits 17:15 source code. Bits in mask 0x7C14 are never stored and read 0. Every other bit reads back as written.
- R4: Source code 001 selects tick_pclk, 010 selects tick_hf and 100 selects tick_lf. Any other code selects nothing, and the counter holds. While the timer is enabled, the counter steps once for every (prescaler+1) strobes of the selected source.
- R5: Status bits 0 to 2 are the compare 1 to 3 flags. A flag is set when the counter steps onto that channel's value, whatever the interrupt-enable bits are.
- R6: In restart mode (free-run bit 0), the step after the counter equals compare 1 takes it to 0. In free-running mode the counter continues counting up instead.
- R7: A step taken at the all-ones count wraps the counter to 0 and sets status bit 5 (rollover).
- R8: Writing status clears each bit written as 1 and leaves bits written as 0. If a flag is set in the same cycle it is cleared, the set wins.
- R9: irq is high exactly when (status AND interrupt-enable) is nonzero and the enable bit is 1.
- R10: When enable goes from 0 to 1 with enable-mode 1, the counter restarts from 0. With enable-mode 0, it resumes from its held value. While disabled, the counter holds.
- R11: In restart mode, any write to compare 1 clears the counter. In free-running mode the write leaves the counter unchanged.
- R12: Writing control with bit 8 set stores the written word with the enable, enable-mode, stop, doze, wait and debug bits cleared. It also zeroes status, prescaler, interrupt-enable and counter, and loads all three compare registers with all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_pclk | input | 1 | Peripheral-clock source strobe, one clk cycle per source tick |
| tick_hf | input | 1 | High-frequency source strobe |
| tick_lf | input | 1 | Low-frequency (32 kHz) source strobe |
| bus_addr | input | ADDR_W | Word offset for read and write |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A status write that clears a compare flag can land in the same cycle that a counter step sets that flag again. The bench provokes this by moving compare 2 one count ahead of the counter. It then drives the clear write and a source strobe on the same clock edge, and expects the flag to read back as set. A plain clear afterwards must then empty it. The same overlap is tested with a compare-1 write in restart mode: the write clears the counter, and a strobe arriving with it must not advance the count. Beyond that, the bench sweeps all eight source codes against four prescaler values, with strobes on every source line.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int OFF_CTL  = 0;
   localparam int OFF_PRE  = 1;
   localparam int OFF_STS  = 2;
   localparam int OFF_IER  = 3;
   localparam int OFF_CMP1 = 4;
   localparam int OFF_CMP2 = 5;
   localparam int OFF_CMP3 = 6;
   localparam int OFF_CAP1 = 7;
   localparam int OFF_CAP2 = 8;
   localparam int OFF_CNT  = 9;

   localparam int B_EN     = 0;
   localparam int B_ENMOD  = 1;
   localparam int B_DBG    = 3;
   localparam int B_WAIT   = 5;
   localparam int B_DOZE   = 6;
   localparam int B_STOP   = 7;
   localparam int B_SWR    = 8;
   localparam int B_FRR    = 9;
   localparam int B_SRC_LO = 15;

   localparam logic [31:0] CTL_DROP = 32'h0000_7C14;
   localparam logic [31:0] CTL_SWR_CLR =
      (32'd1 << B_EN) | (32'd1 << B_ENMOD) | (32'd1 << B_DBG) |
      (32'd1 << B_WAIT) | (32'd1 << B_DOZE) | (32'd1 << B_STOP);

   localparam int NCMP   = 3;
   localparam int FLAG_W = 6;
   localparam int F_ROLL = 5;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [2:0]       src_sel,
   input  logic [PRE_W-1:0] pre,
   input  logic             tick_pclk,
   input  logic             tick_hf,
   input  logic             tick_lf,
   output logic             adv
);
   logic [PRE_W-1:0] div_q;
   logic             src_tick;
   logic             step;

   always_comb begin
      case (src_sel)
         3'b001:  src_tick = tick_pclk;
         3'b010:  src_tick = tick_hf;
         3'b100:  src_tick = tick_lf;
         default: src_tick = 1'b0;
      endcase
   end

   assign step = run & src_tick & ~clear;
   assign adv  = step & (div_q == pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     div_q <= '0;
      else if (clear) div_q <= '0;
      else if (step)  div_q <= (div_q == pre) ? '0 : div_q + 1'b1;
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 32,
   parameter int NCMP  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adv,
   input  logic                       zero,
   input  logic                       restart_mode,
   input  logic [NCMP-1:0][CNT_W-1:0] cmp,
   output logic [CNT_W-1:0]           cnt,
   output logic [NCMP-1:0]            hit,
   output logic                       wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             step;

   assign step = adv & ~zero;

   always_comb begin
      if (restart_mode && cnt_q == cmp[0]) cnt_nxt = '0;
      else if (cnt_q == CNT_MAX)          cnt_nxt = '0;
      else                                cnt_nxt = cnt_q + 1'b1;
   end

   assign wrap = step & (cnt_q == CNT_MAX);

   for (genvar i = 0; i < NCMP; i++) begin : g_match
      assign hit[i] = step & (cnt_nxt == cmp[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (zero) cnt_q <= '0;
      else if (adv)  cnt_q <= cnt_nxt;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_pclk,
   input  logic              tick_hf,
   input  logic              tick_lf,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin : chk_params
      assert (CNT_W >= 2 && CNT_W <= 32) else $fatal(1, "CNT_W out of range");
      assert (PRE_W >= 1 && PRE_W <= 32) else $fatal(1, "PRE_W out of range");
      assert (ADDR_W >= 4) else $fatal(1, "ADDR_W too narrow for map");
   end

   logic [31:0]                 ctl_q;
   logic [PRE_W-1:0]            pre_q;
   logic [FLAG_W-1:0]           sts_q;
   logic [FLAG_W-1:0]           ier_q;
   logic [NCMP-1:0][CNT_W-1:0]  cmp_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [NCMP-1:0]             hit;
   logic                        wrap;
   logic                        cnt_adv;

   logic wr_ctl, wr_pre, wr_sts, wr_ier;
   logic [NCMP-1:0] wr_cmp;
   logic swr, en_rise, cnt_zero, div_clear;
   logic [FLAG_W-1:0] sts_set, sts_clr;

   assign wr_ctl = bus_wr && bus_addr == ADDR_W'(OFF_CTL);
   assign wr_pre = bus_wr && bus_addr == ADDR_W'(OFF_PRE);
   assign wr_sts = bus_wr && bus_addr == ADDR_W'(OFF_STS);
   assign wr_ier = bus_wr && bus_addr == ADDR_W'(OFF_IER);

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp_dec
      assign wr_cmp[i] = bus_wr && bus_addr == ADDR_W'(OFF_CMP1 + i);
   end

   assign swr       = wr_ctl & bus_wdata[B_SWR];
   assign en_rise   = wr_ctl & ~swr & ~ctl_q[B_EN] & bus_wdata[B_EN];
   assign cnt_zero  = swr | (en_rise & bus_wdata[B_ENMOD]) |
                      (wr_cmp[0] & ~ctl_q[B_FRR]);
   assign div_clear = swr | wr_pre | en_rise;

   tmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (div_clear),
      .run       (ctl_q[B_EN]),
      .src_sel   (ctl_q[B_SRC_LO +: 3]),
      .pre       (pre_q),
      .tick_pclk (tick_pclk),
      .tick_hf   (tick_hf),
      .tick_lf   (tick_lf),
      .adv       (cnt_adv)
   );

   tmr_count #(.CNT_W(CNT_W), .NCMP(NCMP)) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv          (cnt_adv),
      .zero         (cnt_zero),
      .restart_mode (~ctl_q[B_FRR]),
      .cmp          (cmp_q),
      .cnt          (cnt_q),
      .hit          (hit),
      .wrap         (wrap)
   );

   assign sts_set = {wrap, {(FLAG_W - NCMP - 1){1'b0}}, hit};
   assign sts_clr = wr_sts ? bus_wdata[FLAG_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         pre_q <= '0;
         sts_q <= '0;
         ier_q <= '0;
         cmp_q <= {NCMP{CNT_MAX}};
      end else if (swr) begin
         ctl_q <= bus_wdata & ~CTL_DROP & ~CTL_SWR_CLR & ~(32'd1 << B_SWR);
         pre_q <= '0;
         sts_q <= '0;
         ier_q <= '0;
         cmp_q <= {NCMP{CNT_MAX}};
      end else begin
         if (wr_ctl) ctl_q <= bus_wdata & ~CTL_DROP;
         if (wr_pre) pre_q <= bus_wdata[PRE_W-1:0];
         if (wr_ier) ier_q <= bus_wdata[FLAG_W-1:0];
         sts_q <= (sts_q & ~sts_clr) | sts_set;
         for (int i = 0; i < NCMP; i++) begin
            if (wr_cmp[i]) cmp_q[i] <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_CTL):  bus_rdata = ctl_q;
         ADDR_W'(OFF_PRE):  bus_rdata[PRE_W-1:0] = pre_q;
         ADDR_W'(OFF_STS):  bus_rdata[FLAG_W-1:0] = sts_q;
         ADDR_W'(OFF_IER):  bus_rdata[FLAG_W-1:0] = ier_q;
         ADDR_W'(OFF_CMP1): bus_rdata[CNT_W-1:0] = cmp_q[0];
         ADDR_W'(OFF_CMP2): bus_rdata[CNT_W-1:0] = cmp_q[1];
         ADDR_W'(OFF_CMP3): bus_rdata[CNT_W-1:0] = cmp_q[2];
         ADDR_W'(OFF_CNT):  bus_rdata[CNT_W-1:0] = cnt_q;
         default:           bus_rdata = '0;
      endcase
   end

   assign irq = ctl_q[B_EN] & (|(sts_q & ier_q));
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic              adv,
   input logic [31:0]       ctl_q,
   input logic [FLAG_W-1:0] sts_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  cmp1
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !bus_wr) |=> $stable(cnt_q)); // R4

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !bus_wr && cnt_q != CNT_MAX && !(!ctl_q[B_FRR] && cnt_q == cmp1))
      |=> cnt_q == $past(cnt_q) + 1'b1); // R4

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !bus_wr && !ctl_q[B_FRR] && cnt_q == cmp1) |=> cnt_q == '0); // R6

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !bus_wr && cnt_q == CNT_MAX) |=> (cnt_q == '0 && sts_q[F_ROLL])); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R8

   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[B_EN] |-> !irq); // R9

   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_CTL) && bus_wdata[B_SWR])
      |=> (cnt_q == '0 && sts_q == '0 && !ctl_q[B_EN])); // R12
endmodule

bind cmp_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .adv       (cnt_adv),
   .ctl_q     (ctl_q),
   .sts_q     (sts_q),
   .cnt_q     (cnt_q),
   .cmp1      (cmp_q[0])
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int PW = 3;
   localparam logic [31:0] CMAX = 32'h0000_00FF;
   localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, SWR = 32'h100, FRR = 32'h200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_pclk = 1'b0, tick_hf = 1'b0, tick_lf = 1'b0;
   logic [3:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;
   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_timer #(.CNT_W(CW), .PRE_W(PW), .ADDR_W(4)) u_cmp_timer (
      .clk(clk), .rst_n(rst_n), .tick_pclk(tick_pclk), .tick_hf(tick_hf),
      .tick_lf(tick_lf), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = 4'(a);
      #1 check(req, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string req, input logic exp);
      @(negedge clk);
      #1 check(req, {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic pulse(input int line, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick_pclk = (line == 0); tick_hf = (line == 1); tick_lf = (line == 2);
         @(negedge clk);
         tick_pclk = 1'b0; tick_hf = 1'b0; tick_lf = 1'b0;
      end
   endtask

   function automatic logic [31:0] src(input int code);
      return 32'(code) << 15;
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 ctl", 0, 32'h0);
      rd_chk("R1 pre", 1, 32'h0);
      rd_chk("R1 sts", 2, 32'h0);
      rd_chk("R1 ier", 3, 32'h0);
      for (int i = 4; i <= 6; i++) rd_chk("R1 cmp", i, CMAX);
      rd_chk("R1 cnt", 9, 32'h0);
      irq_chk("R1 irq", 1'b0);

      // R3 control mask
      wr(0, 32'hFFFF_FEFF);
      rd_chk("R3 ctl mask", 0, 32'hFFFF_FEFF & ~32'h0000_7C14);
      wr(0, 32'h0);

      // R2 capture slots and unmapped offsets
      rd_chk("R2 cap1", 7, 32'h0);
      rd_chk("R2 cap2", 8, 32'h0);
      for (int a = 10; a < 16; a++) wr(a, 32'hFFFF_FFFF);
      for (int a = 10; a < 16; a++) rd_chk("R2 unmapped", a, 32'h0);
      rd_chk("R2 ctl untouched", 0, 32'h0);
      rd_chk("R2 cmp1 untouched", 4, CMAX);

      // R4 source code x prescaler sweep, strobes on every line
      for (int code = 0; code < 8; code++) begin
         for (int p = 0; p < 4; p++) begin
            wr(0, 32'h0);
            wr(1, 32'(p));
            wr(0, EN | ENMOD | FRR | src(code));
            for (int k = 0; k < 6; k++) begin
               pulse(0, 1); pulse(1, 1); pulse(2, 1);
            end
            rd_chk("R4 sweep cnt", 9,
                   (code == 1 || code == 2 || code == 4) ? 32'(6 / (p + 1)) : 32'h0);
         end
      end

      // R5 compare flag, R9 irq, R8 W1C
      wr(0, 32'h0); wr(1, 32'h0); wr(2, 32'h3F);
      wr(4, 32'hF0); wr(6, 32'hF1); wr(5, 32'h3); wr(3, 32'h0);
      wr(0, EN | ENMOD | FRR | src(1));
      pulse(0, 3);
      rd_chk("R5 cmp2 flag", 2, 32'h02);
      irq_chk("R9 masked", 1'b0);
      wr(3, 32'h02);
      irq_chk("R9 enabled", 1'b1);
      wr(2, 32'h01);
      rd_chk("R8 zero-write keeps", 2, 32'h02);
      wr(2, 32'h02);
      rd_chk("R8 one-write clears", 2, 32'h00);
      irq_chk("R9 after clear", 1'b0);

      // R8 same-cycle set and clear: set wins
      wr(5, 32'h4);
      pulse(0, 1);
      rd_chk("R5 cmp2 at 4", 2, 32'h02);
      wr(5, 32'h5);
      @(negedge clk);
      bus_addr = 4'd2; bus_wr = 1'b1; bus_wdata = 32'h02; tick_pclk = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick_pclk = 1'b0;
      rd_chk("R8 set wins", 2, 32'h02);
      rd_chk("R8 cnt stepped", 9, 32'h5);
      irq_chk("R9 flag+ier", 1'b1);

      // R9 gated by enable, R10 resume / restart
      wr(0, FRR | src(1));
      irq_chk("R9 disabled", 1'b0);
      pulse(0, 2);
      rd_chk("R10 hold disabled", 9, 32'h5);
      wr(0, EN | FRR | src(1));
      pulse(0, 1);
      rd_chk("R10 resume", 9, 32'h6);
      wr(0, FRR | src(1));
      wr(0, EN | ENMOD | FRR | src(1));
      rd_chk("R10 enmod clears", 9, 32'h0);

      // R6 restart on compare 1, R11 compare-1 write clears
      wr(0, 32'h0); wr(2, 32'h3F); wr(3, 32'h0);
      wr(5, 32'hF2);
      wr(4, 32'h4);
      wr(0, EN | src(1));
      pulse(0, 4);
      rd_chk("R6 reached cmp1", 9, 32'h4);
      rd_chk("R5 cmp1 flag", 2, 32'h01);
      pulse(0, 1);
      rd_chk("R6 restart", 9, 32'h0);
      pulse(0, 3);
      rd_chk("R6 counting", 9, 32'h3);
      wr(4, 32'h4);
      rd_chk("R11 restart-mode write", 9, 32'h0);
      pulse(0, 2);
      @(negedge clk);
      bus_addr = 4'd4; bus_wr = 1'b1; bus_wdata = 32'h4; tick_pclk = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick_pclk = 1'b0;
      rd_chk("R11 write beats step", 9, 32'h0);

      // R7 rollover, R11 free-run write leaves counter
      wr(0, 32'h0); wr(2, 32'h3F);
      wr(4, 32'h80); wr(5, 32'h81); wr(6, 32'h82);
      wr(0, EN | ENMOD | FRR | src(2));
      pulse(1, 255);
      rd_chk("R7 at max", 9, CMAX);
      rd_chk("R7 no roll yet", 2, 32'h07);
      pulse(1, 1);
      rd_chk("R7 wrapped", 9, 32'h0);
      rd_chk("R7 roll flag", 2, 32'h27);
      wr(3, 32'h20);
      irq_chk("R9 roll irq", 1'b1);
      pulse(1, 3);
      wr(4, 32'h10);
      rd_chk("R11 free-run write", 9, 32'h3);

      // R12 soft reset
      wr(1, 32'h5); wr(3, 32'h3F); wr(5, 32'h7);
      wr(0, SWR | FRR | EN | ENMOD | 32'h0000_00E8 | src(4) | 32'h8000_0000);
      rd_chk("R12 ctl", 0, FRR | src(4) | 32'h8000_0000);
      rd_chk("R12 pre", 1, 32'h0);
      rd_chk("R12 sts", 2, 32'h0);
      rd_chk("R12 ier", 3, 32'h0);
      for (int i = 4; i <= 6; i++) rd_chk("R12 cmp", i, CMAX);
      rd_chk("R12 cnt", 9, 32'h0);
      irq_chk("R12 irq", 1'b0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule